// File: doc/BRIEF.md
# Control-Composed 16-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two 16-bit two's-complement operands. It has no opcode decoder. Six raw control bits steer a fixed pipeline of simple stages. Each operand can first be forced to zero and then bitwise inverted. A core then either ANDs or adds the two prepared operands, and the core result can be inverted on its way out. Constants, identity, negation, increment, decrement, addition, subtraction, AND and OR all come from particular settings of these six bits. The block holds no dedicated subtractor and no OR gate array.

Alongside the 16-bit result, the block reports three status bits: whether the result is zero, whether it is negative, and the carry out of the adder. A surrounding datapath uses it by presenting the operands and the control bits in the same cycle and taking the result and flags once they settle. The block has no clock or reset. Any register stage belongs to the user.

Top module: `six_ctl_alu`

## Requirements
- R1: Each operand passes two stages in a fixed order: it is replaced by 0x0000 when its clear bit is 1, and the value from that step is then bitwise inverted when its invert bit is 1. With both bits set the operand becomes 0xFFFF.
- R2: With `use_add` = 0 the core result is the bitwise AND of the two prepared operands (0x9D95 AND 0x00FF gives 0x0095).
- R3: With `use_add` = 1 the core result is the sum of the two prepared operands modulo 2^16 (0x0020 + 0x0047 gives 0x0067).
- R4: With `inv_out` = 1 the core result is bitwise inverted before it appears on `result`. With `inv_out` = 0 it passes unchanged.
- R5: `carry_out` is the carry out of bit 15 of the addition of the prepared operands, taken before output inversion. It is 0 whenever `use_add` = 0, whatever the other bits are.
- R6: `is_zero` is 1 exactly when `result` equals 0x0000.
- R7: `is_neg` equals bit 15 of `result`.
- R8: The control vector (clr_a, inv_a, clr_b, inv_b, use_add, inv_out) = (0,1,0,0,1,1) yields `result` = opnd_a − opnd_b modulo 2^16.
- R9: The vector (0,1,0,1,0,1) yields `result` = opnd_a OR opnd_b (0x5555 OR 0x003F gives 0x557F).
- R10: The vector (1,1,1,1,1,1) yields 0x0001, the vector (1,1,1,0,1,0) yields 0xFFFF, and the vector (0,0,1,1,1,1) yields −opnd_a modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand, two's complement |
| opnd_b | input | 16 | Second operand, two's complement |
| clr_a | input | 1 | Force first operand to zero |
| inv_a | input | 1 | Invert first operand after the clear step |
| clr_b | input | 1 | Force second operand to zero |
| inv_b | input | 1 | Invert second operand after the clear step |
| use_add | input | 1 | Core function: 0 = AND, 1 = add |
| inv_out | input | 1 | Invert the core result |
| result | output | 16 | Final result |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Bit 15 of the result |
| carry_out | output | 1 | Adder carry out, low for AND |

## Verification
The carry flag and the output inversion can act on the same operation. An addition that carries while `inv_out` is set must still raise `carry_out`, even though the visible result is inverted, and a set `inv_out` must never produce a carry under AND. The bench provokes both cases by running every one of the 64 control vectors against the corner operands 0x0000, 0x7FFF, 0x8000 and 0xFFFF and against random pairs. It judges `carry_out` against an independently computed pre-inversion sum and judges `result` and the other two flags against the post-inversion value.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Raw control word, ordered as the bits are listed in the requirements
    typedef struct packed {
        logic clr_a;
        logic inv_a;
        logic clr_b;
        logic inv_b;
        logic use_add;
        logic inv_out;
    } ctl_t;

    typedef enum logic {
        FN_AND = 1'b0,
        FN_ADD = 1'b1
    } core_fn_e;

    localparam int CTL_BITS = 6;

    // Preset vectors used by the checker and the bench
    localparam logic [CTL_BITS-1:0] CTL_SUB     = 6'b010011;
    localparam logic [CTL_BITS-1:0] CTL_OR      = 6'b010101;
    localparam logic [CTL_BITS-1:0] CTL_ONE     = 6'b111111;
    localparam logic [CTL_BITS-1:0] CTL_ALL_ONE = 6'b111010;
    localparam logic [CTL_BITS-1:0] CTL_NEG_A   = 6'b001111;

    function automatic core_fn_e fn_of(input ctl_t c);
        return c.use_add ? FN_ADD : FN_AND;
    endfunction

endpackage

// File: rtl/alu_opnd_stage.sv
module alu_opnd_stage #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         clr,
    input  logic         inv,
    output logic [W-1:0] dout
);
    logic [W-1:0] cleared;

    // Clear first, invert second: the order is part of the contract
    assign cleared = clr ? '0 : din;
    assign dout    = inv ? ~cleared : cleared;
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  core_fn_e     fn,
    output logic [W-1:0] res,
    output logic         carry
);
    localparam int WE = W + 1;

    logic [WE-1:0] sum_ext;
    logic [W-1:0]  and_v;

    assign sum_ext = {1'b0, a} + {1'b0, b};
    assign and_v   = a & b;

    always_comb begin
        unique case (fn)
            FN_ADD: begin
                res   = sum_ext[W-1:0];
                carry = sum_ext[W];
            end
            default: begin
                res   = and_v;
                carry = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic         zero,
    output logic         neg
);
    assign zero = ~|val;
    assign neg  = val[W-1];
endmodule

// File: rtl/six_ctl_alu.sv
module six_ctl_alu
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         clr_a,
    input  logic         inv_a,
    input  logic         clr_b,
    input  logic         inv_b,
    input  logic         use_add,
    input  logic         inv_out,
    output logic [W-1:0] result,
    output logic         is_zero,
    output logic         is_neg,
    output logic         carry_out
);
    localparam int NOPS = 2;

    ctl_t ctl;
    assign ctl = '{clr_a: clr_a, inv_a: inv_a, clr_b: clr_b,
                   inv_b: inv_b, use_add: use_add, inv_out: inv_out};

    logic [NOPS-1:0][W-1:0] raw_op;
    logic [NOPS-1:0][W-1:0] prep_op;
    logic [NOPS-1:0]        clr_v;
    logic [NOPS-1:0]        inv_v;

    assign raw_op[0] = opnd_a;
    assign raw_op[1] = opnd_b;
    assign clr_v     = {ctl.clr_b, ctl.clr_a};
    assign inv_v     = {ctl.inv_b, ctl.inv_a};

    for (genvar i = 0; i < NOPS; i++) begin : g_opnd
        alu_opnd_stage #(.W(W)) u_stage (
            .din  (raw_op[i]),
            .clr  (clr_v[i]),
            .inv  (inv_v[i]),
            .dout (prep_op[i])
        );
    end

    logic [W-1:0] core_res;
    logic         core_carry;

    alu_core #(.W(W)) u_core (
        .a     (prep_op[0]),
        .b     (prep_op[1]),
        .fn    (fn_of(ctl)),
        .res   (core_res),
        .carry (core_carry)
    );

    // Carry is taken ahead of the output inversion
    assign result    = ctl.inv_out ? ~core_res : core_res;
    assign carry_out = core_carry;

    alu_flag_unit #(.W(W)) u_flags (
        .val  (result),
        .zero (is_zero),
        .neg  (is_neg)
    );
endmodule

// File: rtl/six_ctl_alu_chk.sv
module six_ctl_alu_chk
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         clr_a,
    input logic         inv_a,
    input logic         clr_b,
    input logic         inv_b,
    input logic         use_add,
    input logic         inv_out,
    input logic [W-1:0] result,
    input logic         is_zero,
    input logic         is_neg,
    input logic         carry_out
);
    logic [CTL_BITS-1:0] vec;
    logic [W-1:0]        diff;
    logic [W-1:0]        neg_a;

    assign vec   = {clr_a, inv_a, clr_b, inv_b, use_add, inv_out};
    assign diff  = opnd_a - opnd_b;
    assign neg_a = '0 - opnd_a;

    always_comb begin
        if (!use_add) p_and_no_carry_r5: assert (carry_out == 1'b0);
        p_zero_flag_r6: assert (is_zero == (result == '0));
        p_neg_flag_r7:  assert (is_neg == result[W-1]);
        if (vec == CTL_SUB) p_sub_r8: assert (result == diff);
        if (vec == CTL_OR)  p_or_r9:  assert (result == (opnd_a | opnd_b));
        if (vec == CTL_NEG_A) p_neg_a_r10: assert (result == neg_a);
        if (vec == CTL_ONE) p_one_r10: assert (result == W'(1));
    end
endmodule

bind six_ctl_alu six_ctl_alu_chk #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .clr_a     (clr_a),
    .inv_a     (inv_a),
    .clr_b     (clr_b),
    .inv_b     (inv_b),
    .use_add   (use_add),
    .inv_out   (inv_out),
    .result    (result),
    .is_zero   (is_zero),
    .is_neg    (is_neg),
    .carry_out (carry_out)
);

// File: tb/six_ctl_alu_test.sv
module six_ctl_alu_test;
    localparam int W = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [W-1:0] opnd_a, opnd_b, result;
    logic clr_a, inv_a, clr_b, inv_b, use_add, inv_out;
    logic is_zero, is_neg, carry_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    six_ctl_alu #(.W(W)) uut (
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .clr_a(clr_a), .inv_a(inv_a), .clr_b(clr_b), .inv_b(inv_b),
        .use_add(use_add), .inv_out(inv_out),
        .result(result), .is_zero(is_zero), .is_neg(is_neg),
        .carry_out(carry_out)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    // Drive inputs, then sample after the combinational paths settle
    task automatic apply(input logic [5:0] v, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        {clr_a, inv_a, clr_b, inv_b, use_add, inv_out} = v;
        opnd_a = a;
        opnd_b = b;
        #2;
    endtask

    // Expected values built from the requirement text
    task automatic check_vec(input logic [5:0] v, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] pa, pb, core, fin;
        logic [W:0]   s;
        logic         cy;
        apply(v, a, b);
        pa = v[5] ? '0 : a;   pa = v[4] ? ~pa : pa;     // R1
        pb = v[3] ? '0 : b;   pb = v[2] ? ~pb : pb;     // R1
        s  = {1'b0, pa} + {1'b0, pb};
        core = v[1] ? s[W-1:0] : (pa & pb);             // R2 / R3
        cy   = v[1] ? s[W] : 1'b0;                      // R5
        fin  = v[0] ? ~core : core;                     // R4
        chk("R1-R4 result", result, fin);
        chk("R5 carry", W'(carry_out), W'(cy));
        chk("R6 zero", W'(is_zero), W'(fin == '0));
        chk("R7 neg", W'(is_neg), W'(fin[W-1]));
    endtask

    task automatic t_idle;
        apply(6'b000000, '0, '0);
        chk("R2 idle result", result, 16'h0000);
        chk("R6 idle zero flag", W'(is_zero), 16'h0001);
        chk("R5 idle carry", W'(carry_out), 16'h0000);
    endtask

    task automatic t_examples;
        apply(6'b000010, 16'h0020, 16'h0047);
        chk("R3 add example", result, 16'h0067);
        apply(6'b000000, 16'h9D95, 16'h00FF);
        chk("R2 low byte", result, 16'h0095);
        apply(6'b010101, 16'h5555, 16'h003F);
        chk("R9 or example", result, 16'h557F);
        apply(6'b110000, 16'h1234, 16'hA5A5);
        chk("R1 clear then invert", result, 16'hA5A5);
    endtask

    task automatic t_constants;
        apply(6'b111111, 16'h7FFF, 16'h8000);
        chk("R10 constant one", result, 16'h0001);
        apply(6'b111010, 16'h1234, 16'h4321);
        chk("R10 constant minus one", result, 16'hFFFF);
        apply(6'b001111, 16'h0005, 16'h9999);
        chk("R10 negate a", result, 16'hFFFB);
        apply(6'b001111, 16'h8000, 16'h0000);
        chk("R10 negate min", result, 16'h8000);
    endtask

    task automatic t_sub_or;
        logic [W-1:0] cv [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                apply(6'b010011, cv[i], cv[j]);
                chk("R8 subtract", result, cv[i] - cv[j]);
                apply(6'b010101, cv[i], cv[j]);
                chk("R9 or", result, cv[i] | cv[j]);
            end
    endtask

    task automatic t_carry_inverted;
        // carry from raw sum must survive output inversion
        apply(6'b000011, 16'hFFFF, 16'h0001);
        chk("R5 carry with inv_out", W'(carry_out), 16'h0001);
        chk("R4 inverted sum", result, 16'hFFFF);
        apply(6'b000001, 16'hFFFF, 16'hFFFF);
        chk("R5 no carry on AND", W'(carry_out), 16'h0000);
    endtask

    task automatic t_sweep;
        logic [W-1:0] cv [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
        for (int v = 0; v < 64; v++) begin
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    check_vec(6'(v), cv[i], cv[j]);
            for (int k = 0; k < 12; k++)
                check_vec(6'(v), W'($urandom), W'($urandom));
        end
    endtask

    initial begin
        {clr_a, inv_a, clr_b, inv_b, use_add, inv_out} = '0;
        opnd_a = '0;
        opnd_b = '0;
        t_idle();
        t_examples();
        t_constants();
        t_sub_or();
        t_carry_inverted();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule